// File: doc/BRIEF.md
# Fractional Core-Timer Prescaler

This block produces the tick enable that advances the architected timer counter shared by the processor cores. Two already-synchronised source pulses arrive in the system clock domain. One is the crystal reference at 19.2 MHz and the other comes from the processor-side clock. A control register picks the source. A 32-bit prescaler then scales the chosen pulse rate by 2^31 divided by the prescaler value. Each resulting tick adds 1 or 2 to a 64-bit count, and the increment size is also set in the control register.

The scaling is done with a phase accumulator rather than an integer divider. Every selected source pulse adds 2^31 to the phase. When the phase reaches the prescaler value, a tick fires and the prescaler value is subtracted, so the fractional remainder carries over to later pulses. A prescaler of 0x80000000 gives one tick per source pulse. With a control value of zero and that prescaler, the count runs at the crystal rate. Software sets the ratio by writing the prescaler register, and that write restarts the phase.

Top module: `ctp_core_timer_prescaler`

## Requirements
- R1: After reset the tick output is 0, the count is 0, the control register reads 0, and the prescaler register reads 0x80000000.
- R2: Control bit 8 selects the tick source: 0 takes xtal_pulse and 1 takes alt_pulse. Pulses on the source that is not selected change neither tick nor count.
- R3: Control bit 9 sets the count step per tick: 0 adds 1 and 1 adds 2.
- R4: With the prescaler at 0x80000000, every selected source pulse gives a tick in the clock cycle after the pulse.
- R5: For a prescaler P of 2^31 or more, each selected pulse adds 2^31 to the phase. A tick fires when the phase is at least P, and P is then subtracted. The long-run tick rate is therefore the pulse rate times 2^31/P. As an example, P = 0xC0000000 gives no tick, tick, tick over three pulses from a cleared phase.
- R6: A prescaler value below 2^31, including 0, is treated as 2^31, so at most one tick fires per source pulse.
- R7: Writing the prescaler register (address 1) clears the phase. A source pulse in the same cycle as that write produces no tick.
- R8: The count wraps to zero on overflow of its width.
- R9: Address 0 reads back only control bits 8 and 9, with all other bits reading 0. Address 1 reads back the full 32-bit prescaler.
- R10: Tick is a one-cycle pulse, and the count changes on the same clock edge that raises it, never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_pulse | input | 1 | Synchronised pulse, one per crystal reference period |
| alt_pulse | input | 1 | Synchronised pulse, one per processor-side clock period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 prescaler |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register selected by reg_addr |
| tick | output | 1 | One-cycle timer advance enable |
| count | output | 64 | Timer count |

## Verification
The two functions that can land in the same cycle are a prescaler write and a phase step from a selected source pulse. The bench forces both together by raising xtal_pulse on the cycle that writes the prescaler. Beforehand, the prescaler is set to 0xC0000000 and one pulse is applied so that the phase is left at 2^31. The collision is judged correct if that cycle produces no tick, the following pulse also produces none (evidence that the phase was cleared rather than kept), and the pulse after that does tick.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
   localparam int unsigned CTRL_SRC_BIT = 8;   // source select position
   localparam int unsigned CTRL_INC_BIT = 9;   // step-size position
   localparam logic        ADDR_CTRL    = 1'b0;
   localparam logic        ADDR_PRESC   = 1'b1;
endpackage

// File: rtl/ctp_regs.sv
module ctp_regs #(
   parameter int unsigned REG_W       = 32,
   parameter logic [31:0] PRESC_RESET = 32'h8000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             addr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             sel_alt,
   output logic             step_two,
   output logic [REG_W-1:0] presc,
   output logic             presc_wr
);
   import ctp_pkg::*;

   if (REG_W <= CTRL_INC_BIT) begin : g_bad_width
      $error("ctp_regs: REG_W must hold the control fields");
   end

   assign presc_wr = wr && (addr == ADDR_PRESC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_alt  <= 1'b0;
         step_two <= 1'b0;
         presc    <= PRESC_RESET[REG_W-1:0];
      end else if (wr) begin
         if (addr == ADDR_CTRL) begin
            sel_alt  <= wdata[CTRL_SRC_BIT];
            step_two <= wdata[CTRL_INC_BIT];
         end else begin
            presc <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_CTRL) begin
         rdata[CTRL_SRC_BIT] = sel_alt;
         rdata[CTRL_INC_BIT] = step_two;
      end else begin
         rdata = presc;
      end
   end

   // R9: a control write leaves the prescaler untouched
   assert_ctrl_wr_keeps_presc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_CTRL) |=> $stable(presc));
endmodule

// File: rtl/ctp_phase_acc.sv
module ctp_phase_acc #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             clear,
   input  logic [ACC_W-1:0] presc,
   output logic             fire,
   output logic             tick_q
);
   localparam logic [ACC_W-1:0] UNITY = {1'b1, {(ACC_W-1){1'b0}}};

   if (ACC_W < 8) begin : g_bad_acc
      $error("ctp_phase_acc: ACC_W too small");
   end

   logic [ACC_W-1:0] phase;
   logic [ACC_W-1:0] limit;
   logic [ACC_W:0]   sum;
   logic [ACC_W:0]   nxt;
   logic             reach;

   // R6: values below unity behave as unity
   assign limit = (presc < UNITY) ? UNITY : presc;
   assign sum   = {1'b0, phase} + {1'b0, UNITY};
   assign reach = (sum >= {1'b0, limit});
   assign nxt   = reach ? (sum - {1'b0, limit}) : sum;
   // R7: a prescaler write wins over a step in the same cycle
   assign fire  = step && !clear && reach;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= fire;
         if (clear)      phase <= '0;
         else if (step)  phase <= nxt[ACC_W-1:0];
      end
   end

   always_comb begin
      if (rst_n) begin
         assert_phase_fits_R5: assert (nxt[ACC_W] == 1'b0 || !step);
      end
   end

   assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      phase < limit || $past(clear || (presc != limit) || !rst_n) || $changed(presc));

   assert_unity_every_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && presc == UNITY && phase == '0) |=> tick_q);

   assert_clear_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!tick_q && phase == '0));
endmodule

// File: rtl/ctp_counter.sv
module ctp_counter #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             step_two,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] INC_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] INC_TWO = CNT_W'(2);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("ctp_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (adv) cnt <= cnt + (step_two ? INC_TWO : INC_ONE);
   end

   // R10: no advance, no change
   assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(adv)) |-> $stable(cnt));
endmodule

// File: rtl/ctp_core_timer_prescaler.sv
module ctp_core_timer_prescaler #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xtal_pulse,
   input  logic             alt_pulse,
   input  logic             reg_wr,
   input  logic             reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             tick,
   output logic [CNT_W-1:0] count
);
   logic             sel_alt;
   logic             step_two;
   logic [REG_W-1:0] presc;
   logic             presc_wr;
   logic             src_step;
   logic             fire;

   ctp_regs #(.REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .sel_alt(sel_alt),
      .step_two(step_two), .presc(presc), .presc_wr(presc_wr)
   );

   assign src_step = sel_alt ? alt_pulse : xtal_pulse;

   ctp_phase_acc #(.ACC_W(REG_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .step(src_step), .clear(presc_wr),
      .presc(presc), .fire(fire), .tick_q(tick)
   );

   ctp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(fire), .step_two(step_two), .cnt(count)
   );

   // R2: a tick follows only a pulse on the selected source
   assert_tick_from_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> ($past(rst_n) && $past(sel_alt ? alt_pulse : xtal_pulse)));

   // R10: tick never lasts two cycles without a second pulse
   assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !src_step) |=> !tick);
endmodule

// File: tb/tb_ctp_core_timer_prescaler.sv
module tb_ctp_core_timer_prescaler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xtal_pulse = 1'b0;
   logic        alt_pulse = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tick;
   logic [63:0] count;
   logic [31:0] s_rdata;
   logic        s_tick;
   logic [3:0]  s_count;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [63:0] exp_cnt = '0;

   always #5 clk = ~clk;

   ctp_core_timer_prescaler dut (
      .clk(clk), .rst_n(rst_n), .xtal_pulse(xtal_pulse), .alt_pulse(alt_pulse),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .tick(tick), .count(count)
   );

   ctp_core_timer_prescaler #(.CNT_W(4)) dut_small (
      .clk(clk), .rst_n(rst_n), .xtal_pulse(xtal_pulse), .alt_pulse(alt_pulse),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(s_rdata), .tick(s_tick), .count(s_count)
   );

   localparam int NV = 6;
   localparam logic [31:0] V_P [NV] = '{32'h8000_0000, 32'hC000_0000, 32'hFFFF_FFFF,
                                        32'h4000_0000, 32'h0000_0000, 32'hA000_0000};
   localparam int V_N [NV] = '{8, 9, 8, 5, 4, 10};
   localparam int V_T [NV] = '{8, 6, 4, 5, 4, 8};
   localparam string V_R [NV] = '{"R4", "R5", "R5", "R6", "R6", "R5"};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic a, input logic [31:0] d, input logic with_pulse);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; xtal_pulse = with_pulse;
      @(negedge clk);
      reg_wr = 1'b0; xtal_pulse = 1'b0;
   endtask

   task automatic rd_reg(input logic a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic use_alt, output logic t);
      @(negedge clk);
      if (use_alt) alt_pulse = 1'b1; else xtal_pulse = 1'b1;
      @(negedge clk);
      alt_pulse = 1'b0; xtal_pulse = 1'b0;
      t = tick;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic t;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_reg(1'b0, d);
      chk("R1 ctrl", d, 32'h0);
      rd_reg(1'b1, d);
      chk("R1 presc", d, 32'h8000_0000);
      chk("R1 tick", tick, 0);
      chk("R1 count", count, 0);

      // R4 / R10: one pulse, tick next cycle, then gone
      pulse(1'b0, t);
      chk("R4 tick after pulse", t, 1);
      exp_cnt += 1;
      chk("R10 count same edge", count, exp_cnt);
      @(negedge clk);
      chk("R10 tick one cycle", tick, 0);

      // table walk: R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         wr_reg(1'b1, V_P[i], 1'b0);
         n = 0;
         for (int k = 0; k < V_N[i]; k++) begin
            pulse(1'b0, t);
            if (t) n++;
         end
         chk({V_R[i], " ticks"}, n, V_T[i]);
         exp_cnt += 64'(V_T[i]);
         chk({V_R[i], " count"}, count, exp_cnt);
      end

      // R9 readback
      wr_reg(1'b0, 32'hFFFF_FFFF, 1'b0);
      rd_reg(1'b0, d);
      chk("R9 ctrl bits", d, 32'h0000_0300);
      wr_reg(1'b1, 32'h1234_5678, 1'b0);
      rd_reg(1'b1, d);
      chk("R9 presc", d, 32'h1234_5678);
      wr_reg(1'b1, 32'h8000_0000, 1'b0);

      // R2 source select
      wr_reg(1'b0, 32'h0000_0100, 1'b0);
      for (int k = 0; k < 3; k++) pulse(1'b0, t);
      chk("R2 xtal ignored when alt", count, exp_cnt);
      pulse(1'b1, t); pulse(1'b1, t);
      exp_cnt += 2;
      chk("R2 alt counted", count, exp_cnt);
      wr_reg(1'b0, 32'h0, 1'b0);
      pulse(1'b1, t); pulse(1'b1, t);
      chk("R2 alt ignored when xtal", count, exp_cnt);
      pulse(1'b0, t);
      exp_cnt += 1;
      chk("R2 xtal counted", count, exp_cnt);

      // R3 step of two
      wr_reg(1'b0, 32'h0000_0200, 1'b0);
      for (int k = 0; k < 3; k++) pulse(1'b0, t);
      exp_cnt += 6;
      chk("R3 step two", count, exp_cnt);
      wr_reg(1'b0, 32'h0, 1'b0);

      // R7 write collides with a pulse
      wr_reg(1'b1, 32'hC000_0000, 1'b0);
      pulse(1'b0, t);
      chk("R7 first pulse no tick", t, 0);
      wr_reg(1'b1, 32'hC000_0000, 1'b1);
      chk("R7 no tick on write cycle", tick, 0);
      pulse(1'b0, t);
      chk("R7 phase cleared", t, 0);
      pulse(1'b0, t);
      chk("R7 tick after clear", t, 1);
      exp_cnt += 1;
      chk("R7 count", count, exp_cnt);

      // R8 wrap on narrow instance
      chk("R8 wrap", s_count, exp_cnt[3:0]);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule